// File: doc/BRIEF.md
# Stacked Register Frame Manager

This block renames logical integer register numbers onto a physical register file. Logical registers 0 to 31 are global: they are never renamed and are always visible. Logical registers 32 to 127 are stacked. Each procedure sees a private frame of variable size that starts at logical register 32. Frames are placed one after another on a circular physical stacked area of `NPS` entries.

A call request carries the size of the new frame. If the stacked area cannot hold the resident caller registers plus the new frame, the oldest resident caller registers are written out to a backing store through a memory request/acknowledge port until the new frame fits. A return request restores the caller's size and base. If part of the caller's frame was written out earlier, the missing registers are read back first, newest address first. A flush request writes every resident caller register to memory, as needed on a context switch. A backing-store pointer tracks the next free memory slot. Software never issues save or restore code. The block is polled through `ready_o`, and the rename lookup is combinational.

Top module: `rsf_frame_mgr`

## Requirements
- R1: A logical register below 32 maps to the physical register with the same number, and `illegal_o` stays 0 for it.
- R2: A logical register r of 32 or more with r-32 below the current frame size maps to physical index 32 + ((bof + r - 32) mod NPS), where bof is the ring slot of the frame bottom. Any other r of 32 or more sets `illegal_o` and drives `preg_o` to 0.
- R3: An accepted call with size n places the new frame's bottom at the ring slot just after the caller's frame and sets the frame size to n. `ready_o` is low for at least one cycle after acceptance. No memory request is made while `ready_o` is high.
- R4: While the resident caller registers plus n exceed NPS, the manager spills the oldest resident register. A spill is a request with `mem_we_o`=1, `mem_addr_o` equal to the backing-store pointer, and `mem_preg_o` equal to that register's physical index. Each acknowledge increments the pointer, and a new spill can follow in the next cycle.
- R5: On return, if fewer caller registers are resident than the caller's size, the manager fills one register per acknowledge. A fill is a request with `mem_we_o`=0, `mem_addr_o` equal to the pointer minus 1, and `mem_preg_o` equal to the ring slot just below the oldest resident register. Each acknowledge decrements the pointer.
- R6: After a return completes, the frame size and base are those the caller had before its call.
- R7: A flush spills every resident caller register, oldest first, as in R4. The current frame's size and mapping are unchanged afterwards.
- R8: A call with a size above NPS, a call while `MAX_DEPTH` frames are saved, and a return with no saved frame are all ignored. `ready_o` stays 1 and the frame size and mapping do not change.
- R9: When requests coincide in a ready cycle, flush wins over call and call wins over return. A call with an illegal size does not let a simultaneous return through.
- R10: A memory request holds `mem_we_o`, `mem_addr_o` and `mem_preg_o` stable until it is acknowledged.
- R11: After reset `ready_o` is 1, the frame size is 0, every stacked logical register is illegal, `bsp_o` is 0 and `mem_req_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| call_i | input | 1 | Allocate a new frame (sampled when ready) |
| call_size_i | input | 7 | Size of the new frame |
| ret_i | input | 1 | Return to the caller's frame |
| flush_i | input | 1 | Spill every resident caller register |
| ready_o | output | 1 | Idle and accepting requests; lookup valid |
| lreg_i | input | 7 | Logical register to rename |
| preg_o | output | 7 | Physical register index |
| illegal_o | output | 1 | Logical register outside the current frame |
| mem_req_o | output | 1 | Spill or fill request pending |
| mem_we_o | output | 1 | 1 = spill (register to memory), 0 = fill |
| mem_addr_o | output | 16 | Backing-store slot |
| mem_preg_o | output | 7 | Physical register being moved |
| mem_ack_i | input | 1 | Memory has completed the pending transfer |
| bsp_o | output | 16 | Backing-store pointer |
| frame_size_o | output | 7 | Current frame size |

## Verification
The bench drives frames so that the ring pointer wraps past the top of the stacked area. A design that wraps with a plain power-of-two mask would send registers to physical slots outside the file. A call that overflows checks that the oldest registers leave first at rising addresses. The returns that follow check that fills come back at falling addresses into the exact slots that were vacated; a design with an off-by-one in the fill slot corrupts the caller's frame. Flush arriving together with a call, and call together with return, check the priority order. Acknowledges are held back for varying lengths of time to expose requests that change before they are acknowledged. Oversize calls, calls at full depth and returns from an empty stack check that a design updating state anyway changes the frame size or drops `ready_o`.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
  typedef logic [15:0] idx_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CALL,
    ST_RET,
    ST_FLUSH
  } seq_state_e;

  function automatic idx_t ring_add(idx_t a, idx_t b, idx_t n);
    idx_t s;
    s = a + b;
    return (s >= n) ? s - n : s;
  endfunction

  function automatic idx_t ring_sub(idx_t a, idx_t b, idx_t n);
    return (a >= b) ? a - b : a + n - b;
  endfunction
endpackage

// File: rtl/rsf_rename.sv
module rsf_rename
  import rsf_pkg::*;
#(
  parameter int NUM_GLB = 32,
  parameter int NPS     = 40,
  parameter int LW      = 7,
  parameter int PW      = 7,
  parameter int PSW     = 6,
  parameter int CW      = 7
) (
  input  logic [LW-1:0]  lreg_i,
  input  logic [PSW-1:0] bof_i,
  input  logic [CW-1:0]  sof_i,
  output logic [PW-1:0]  preg_o,
  output logic           illegal_o
);
  idx_t lreg_x, off_x, slot_x, phys_x;

  always_comb begin
    lreg_x    = idx_t'(lreg_i);
    off_x     = lreg_x - idx_t'(NUM_GLB);
    slot_x    = '0;
    phys_x    = '0;
    illegal_o = 1'b0;
    if (lreg_x < idx_t'(NUM_GLB)) begin
      phys_x = lreg_x;
    end else if (off_x < idx_t'(sof_i)) begin
      slot_x = ring_add(idx_t'(bof_i), off_x, idx_t'(NPS));
      phys_x = idx_t'(NUM_GLB) + slot_x;
    end else begin
      illegal_o = 1'b1;
    end
    preg_o = phys_x[PW-1:0];
  end
endmodule

// File: rtl/rsf_frame_stack.sv
module rsf_frame_stack #(
  parameter int DEPTH = 4,
  parameter int CW    = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [CW-1:0] push_val_i,
  output logic [CW-1:0] top_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int DW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [DW-1:0] ONE_D = 1;

  logic [DW-1:0] cnt_q, top_idx;
  logic [DEPTH-1:0][CW-1:0] slots;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [CW-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q <= '0;
      else if (push_i && cnt_q == DW'(i)) slot_q <= push_val_i;
    end
    assign slots[i] = slot_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (push_i && !full_o) cnt_q <= cnt_q + ONE_D;
    else if (pop_i && !empty_o) cnt_q <= cnt_q - ONE_D;
  end

  assign full_o  = (cnt_q == DW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign top_idx = cnt_q - ONE_D;
  assign top_o   = empty_o ? '0 : slots[top_idx[IW-1:0]];
endmodule

// File: rtl/rsf_seq.sv
module rsf_seq
  import rsf_pkg::*;
#(
  parameter int NPS = 40,
  parameter int AW  = 16,
  parameter int CW  = 7,
  parameter int PSW = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           call_i,
  input  logic [CW-1:0]  call_size_i,
  input  logic           ret_i,
  input  logic           flush_i,
  input  logic           mem_ack_i,
  input  logic           stk_full_i,
  input  logic           stk_empty_i,
  input  logic [CW-1:0]  stk_top_i,
  output logic           ready_o,
  output logic           push_o,
  output logic           pop_o,
  output logic [CW-1:0]  push_val_o,
  output logic [PSW-1:0] bof_o,
  output logic [CW-1:0]  sof_o,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [PSW-1:0] mem_slot_o,
  output logic [AW-1:0]  bsp_o
);
  localparam logic [AW-1:0] ONE_A = 1;
  localparam logic [CW-1:0] ONE_C = 1;

  seq_state_e    state_q;
  logic [PSW-1:0] bof_q;
  logic [CW-1:0]  sof_q, ndirty_q, target_q;
  logic [AW-1:0]  bsp_q;

  logic idle, size_ok, do_flush, do_call, do_ret;
  logic need_spill, need_fill, xfer;
  idx_t bof_call, bof_ret, spill_slot, fill_slot;

  always_comb begin
    idle     = (state_q == ST_IDLE);
    size_ok  = idx_t'(call_size_i) <= idx_t'(NPS);
    do_flush = idle && flush_i;
    do_call  = idle && !flush_i && call_i && size_ok && !stk_full_i;
    do_ret   = idle && !flush_i && !call_i && ret_i && !stk_empty_i;

    need_spill = ((state_q == ST_CALL) &&
                  (idx_t'(ndirty_q) + idx_t'(target_q) > idx_t'(NPS))) ||
                 ((state_q == ST_FLUSH) && (ndirty_q != '0));
    need_fill  = (state_q == ST_RET) && (ndirty_q < target_q);
    xfer       = (need_spill || need_fill) && mem_ack_i;

    bof_call   = ring_add(idx_t'(bof_q), idx_t'(sof_q), idx_t'(NPS));
    bof_ret    = ring_sub(idx_t'(bof_q), idx_t'(target_q), idx_t'(NPS));
    spill_slot = ring_sub(idx_t'(bof_q), idx_t'(ndirty_q), idx_t'(NPS));
    fill_slot  = ring_sub(idx_t'(bof_q), idx_t'(ndirty_q) + 16'd1, idx_t'(NPS));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      bof_q    <= '0;
      sof_q    <= '0;
      ndirty_q <= '0;
      target_q <= '0;
      bsp_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (do_flush) begin
            state_q <= ST_FLUSH;
          end else if (do_call) begin
            bof_q    <= bof_call[PSW-1:0];
            ndirty_q <= ndirty_q + sof_q;
            target_q <= call_size_i;
            sof_q    <= '0;
            state_q  <= ST_CALL;
          end else if (do_ret) begin
            target_q <= stk_top_i;
            sof_q    <= '0;
            state_q  <= ST_RET;
          end
        end
        ST_CALL, ST_FLUSH: begin
          if (xfer) begin
            ndirty_q <= ndirty_q - ONE_C;
            bsp_q    <= bsp_q + ONE_A;
          end else if (!need_spill) begin
            if (state_q == ST_CALL) sof_q <= target_q;
            state_q <= ST_IDLE;
          end
        end
        ST_RET: begin
          if (xfer) begin
            ndirty_q <= ndirty_q + ONE_C;
            bsp_q    <= bsp_q - ONE_A;
          end else if (!need_fill) begin
            bof_q    <= bof_ret[PSW-1:0];
            ndirty_q <= ndirty_q - target_q;
            sof_q    <= target_q;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o    = idle;
  assign push_o     = do_call;
  assign pop_o      = do_ret;
  assign push_val_o = sof_q;
  assign bof_o      = bof_q;
  assign sof_o      = sof_q;
  assign mem_req_o  = need_spill || need_fill;
  assign mem_we_o   = need_spill;
  assign mem_addr_o = need_fill ? bsp_q - ONE_A : bsp_q;
  assign mem_slot_o = need_fill ? fill_slot[PSW-1:0] : spill_slot[PSW-1:0];
  assign bsp_o      = bsp_q;
endmodule

// File: rtl/rsf_frame_mgr.sv
module rsf_frame_mgr #(
  parameter int NUM_LOG   = 128,
  parameter int NUM_GLB   = 32,
  parameter int NPS       = 40,
  parameter int MAX_DEPTH = 4,
  parameter int AW        = 16,
  localparam int LW  = $clog2(NUM_LOG),
  localparam int PW  = $clog2(NUM_GLB + NPS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          call_i,
  input  logic [LW-1:0] call_size_i,
  input  logic          ret_i,
  input  logic          flush_i,
  output logic          ready_o,
  input  logic [LW-1:0] lreg_i,
  output logic [PW-1:0] preg_o,
  output logic          illegal_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [PW-1:0] mem_preg_o,
  input  logic          mem_ack_i,
  output logic [AW-1:0] bsp_o,
  output logic [LW-1:0] frame_size_o
);
  localparam int PSW = (NPS > 1) ? $clog2(NPS) : 1;
  localparam int CW  = LW;

  logic           push, pop, stk_full, stk_empty;
  logic [CW-1:0]  push_val, stk_top, sof;
  logic [PSW-1:0] bof, mem_slot;

  rsf_seq #(.NPS(NPS), .AW(AW), .CW(CW), .PSW(PSW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .call_i      (call_i),
    .call_size_i (call_size_i),
    .ret_i       (ret_i),
    .flush_i     (flush_i),
    .mem_ack_i   (mem_ack_i),
    .stk_full_i  (stk_full),
    .stk_empty_i (stk_empty),
    .stk_top_i   (stk_top),
    .ready_o     (ready_o),
    .push_o      (push),
    .pop_o       (pop),
    .push_val_o  (push_val),
    .bof_o       (bof),
    .sof_o       (sof),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_slot_o  (mem_slot),
    .bsp_o       (bsp_o)
  );

  rsf_frame_stack #(.DEPTH(MAX_DEPTH), .CW(CW)) u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .pop_i      (pop),
    .push_val_i (push_val),
    .top_o      (stk_top),
    .full_o     (stk_full),
    .empty_o    (stk_empty)
  );

  rsf_rename #(
    .NUM_GLB(NUM_GLB), .NPS(NPS), .LW(LW), .PW(PW), .PSW(PSW), .CW(CW)
  ) u_rename (
    .lreg_i    (lreg_i),
    .bof_i     (bof),
    .sof_i     (sof),
    .preg_o    (preg_o),
    .illegal_o (illegal_o)
  );

  assign mem_preg_o   = PW'(NUM_GLB) + PW'(mem_slot);
  assign frame_size_o = sof;
endmodule

// File: rtl/rsf_frame_mgr_sva.sv
module rsf_frame_mgr_sva #(
  parameter int NUM_GLB = 32,
  parameter int NPS     = 40,
  parameter int LW      = 7,
  parameter int PW      = 7,
  parameter int AW      = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          call_i,
  input logic [LW-1:0] call_size_i,
  input logic          flush_i,
  input logic          ready_o,
  input logic [LW-1:0] lreg_i,
  input logic [PW-1:0] preg_o,
  input logic          illegal_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [PW-1:0] mem_preg_o,
  input logic          mem_ack_i,
  input logic [AW-1:0] bsp_o,
  input logic [LW-1:0] frame_size_o
);
  assert_global_identity_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && int'(lreg_i) < NUM_GLB) |-> (!illegal_o && int'(preg_o) == int'(lreg_i)));

  assert_outside_frame_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && int'(lreg_i) >= NUM_GLB && int'(lreg_i) - NUM_GLB >= int'(frame_size_o))
    |-> (illegal_o && preg_o == '0));

  assert_idle_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !mem_req_o);

  assert_spill_bump_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_ack_i) |=> (bsp_o == $past(bsp_o) + AW'(1)));

  assert_fill_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_ack_i) |=> (bsp_o == $past(bsp_o) - AW'(1)));

  assert_flush_keeps_size_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && flush_i) |=> $stable(frame_size_o));

  assert_oversize_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && call_i && !flush_i && int'(call_size_i) > NPS)
    |=> (ready_o && $stable(frame_size_o)));

  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=>
      (mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o) && $stable(mem_preg_o)));
endmodule

bind rsf_frame_mgr rsf_frame_mgr_sva #(
  .NUM_GLB(NUM_GLB), .NPS(NPS), .LW(LW), .PW(PW), .AW(AW)
) u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .call_i       (call_i),
  .call_size_i  (call_size_i),
  .flush_i      (flush_i),
  .ready_o      (ready_o),
  .lreg_i       (lreg_i),
  .preg_o       (preg_o),
  .illegal_o    (illegal_o),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_preg_o   (mem_preg_o),
  .mem_ack_i    (mem_ack_i),
  .bsp_o        (bsp_o),
  .frame_size_o (frame_size_o)
);

// File: tb/rsf_frame_mgr_test.sv
module rsf_frame_mgr_test;
  localparam int NPS = 40;
  localparam int AW  = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic call_i = 1'b0, ret_i = 1'b0, flush_i = 1'b0, mem_ack_i = 1'b0;
  logic [6:0] call_size_i = '0, lreg_i = '0;
  logic ready_o, illegal_o, mem_req_o, mem_we_o;
  logic [6:0] preg_o, mem_preg_o, frame_size_o;
  logic [AW-1:0] mem_addr_o, bsp_o;

  always #5 clk = ~clk;

  rsf_frame_mgr #(.NPS(NPS), .MAX_DEPTH(4), .AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .call_i(call_i), .call_size_i(call_size_i),
    .ret_i(ret_i), .flush_i(flush_i), .ready_o(ready_o), .lreg_i(lreg_i),
    .preg_o(preg_o), .illegal_o(illegal_o), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_preg_o(mem_preg_o),
    .mem_ack_i(mem_ack_i), .bsp_o(bsp_o), .frame_size_o(frame_size_o)
  );

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [6:0]    preg;
  } mem_op_t;

  mem_op_t exp_q[$];
  int n_tests = 0, n_fail = 0, lat_mode = 0, lat_seq = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // scoreboard expectations
  task automatic exp_spill(input int addr, input int preg);
    exp_q.push_back('{we: 1'b1, addr: AW'(addr), preg: 7'(preg)});
  endtask
  task automatic exp_fill(input int addr, input int preg);
    exp_q.push_back('{we: 1'b0, addr: AW'(addr), preg: 7'(preg)});
  endtask

  // monitor: pops expected transfers, varies acknowledge latency
  initial begin
    mem_op_t cap;
    bit hold = 1'b0;
    int wcnt = 0;
    forever begin
      @(negedge clk);
      mem_ack_i = 1'b0;
      if (mem_req_o) begin
        if (!hold) begin
          cap  = '{we: mem_we_o, addr: mem_addr_o, preg: mem_preg_o};
          hold = 1'b1;
          wcnt = lat_mode ? (lat_seq % 3) : 0;
          lat_seq++;
        end else begin
          chk(cap == {mem_we_o, mem_addr_o, mem_preg_o}, "R10 request held",
              int'(mem_addr_o), int'(cap.addr));
        end
        if (wcnt == 0) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R4/R5 unexpected transfer", int'(cap.addr), -1);
          end else begin
            mem_op_t e;
            e = exp_q.pop_front();
            chk(cap.we == e.we, e.we ? "R4 spill direction" : "R5 fill direction",
                int'(cap.we), int'(e.we));
            chk(cap.addr == e.addr, e.we ? "R4 spill address" : "R5 fill address",
                int'(cap.addr), int'(e.addr));
            chk(cap.preg == e.preg, e.we ? "R4 spill register" : "R5 fill register",
                int'(cap.preg), int'(e.preg));
          end
          mem_ack_i = 1'b1;
          hold = 1'b0;
        end else begin
          wcnt--;
        end
      end
    end
  end

  task automatic op(input bit c, input int sz, input bit r, input bit f);
    @(negedge clk);
    call_i = c; call_size_i = 7'(sz); ret_i = r; flush_i = f;
    @(negedge clk);
    call_i = 1'b0; ret_i = 1'b0; flush_i = 1'b0;
    while (!ready_o) @(negedge clk);
  endtask

  task automatic map(input int lreg, input int preg, input bit ill, input string tag);
    @(negedge clk);
    lreg_i = 7'(lreg);
    #1;
    chk(illegal_o == ill, tag, int'(illegal_o), int'(ill));
    chk(int'(preg_o) == preg, tag, int'(preg_o), preg);
  endtask

  task automatic size_is(input int sz, input string tag);
    chk(int'(frame_size_o) == sz, tag, int'(frame_size_o), sz);
  endtask

  // watchdog
  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      chk(1'b0, "watchdog expired", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(ready_o == 1'b1, "R11 ready after reset", int'(ready_o), 1);
    chk(mem_req_o == 1'b0, "R11 no request", int'(mem_req_o), 0);
    chk(bsp_o == '0, "R11 pointer zero", int'(bsp_o), 0);
    size_is(0, "R11 frame size zero");
    map(32, 0, 1'b1, "R11 stacked illegal");

    // R3 first frame, R1 globals
    op(1'b1, 10, 1'b0, 1'b0);
    size_is(10, "R3 frame size");
    map(5, 5, 1'b0, "R1 global 5");
    map(31, 31, 1'b0, "R1 global 31");
    map(32, 32, 1'b0, "R2 first slot");
    map(41, 41, 1'b0, "R2 last slot");
    map(42, 0, 1'b1, "R2 beyond frame");

    op(1'b1, 20, 1'b0, 1'b0);
    map(32, 42, 1'b0, "R3 base after caller");

    // R4 overflow spill, slow acks
    lat_mode = 1;
    for (int i = 0; i < 5; i++) exp_spill(i, 32 + i);
    op(1'b1, 15, 1'b0, 1'b0);
    chk(exp_q.size() == 0, "R4 spill count", exp_q.size(), 0);
    chk(int'(bsp_o) == 5, "R4 pointer", int'(bsp_o), 5);
    map(32, 62, 1'b0, "R2 mapping");
    map(46, 36, 1'b0, "R2 ring wrap");
    map(47, 0, 1'b1, "R2 beyond frame");

    // R6 return without fill
    op(1'b0, 0, 1'b1, 1'b0);
    size_is(20, "R6 caller size");
    map(32, 42, 1'b0, "R6 caller base");

    // R5 return with fill
    for (int i = 4; i >= 0; i--) exp_fill(i, 32 + i);
    op(1'b0, 0, 1'b1, 1'b0);
    chk(exp_q.size() == 0, "R5 fill count", exp_q.size(), 0);
    chk(int'(bsp_o) == 0, "R5 pointer", int'(bsp_o), 0);
    size_is(10, "R6 caller size");
    map(32, 32, 1'b0, "R6 caller base");

    // R8 oversize call
    @(negedge clk);
    call_i = 1'b1; call_size_i = 7'(NPS + 1);
    @(negedge clk);
    call_i = 1'b0;
    chk(ready_o == 1'b1, "R8 oversize keeps ready", int'(ready_o), 1);
    size_is(10, "R8 oversize ignored");

    lat_mode = 0;
    op(1'b1, 30, 1'b0, 1'b0);
    map(61, 71, 1'b0, "R3 frame fills ring");

    // R9 flush beats call, R7 flush
    for (int i = 0; i < 10; i++) exp_spill(i, 32 + i);
    op(1'b1, 5, 1'b0, 1'b1);
    chk(exp_q.size() == 0, "R7 flush spill count", exp_q.size(), 0);
    size_is(30, "R9 flush wins over call");
    map(32, 42, 1'b0, "R7 mapping kept");

    // R9 call beats return, base wraps to 0
    op(1'b1, 7, 1'b1, 1'b0);
    size_is(7, "R9 call wins over return");
    map(32, 32, 1'b0, "R3 base wraps");
    map(38, 38, 1'b0, "R2 last slot");

    op(1'b0, 0, 1'b1, 1'b0);
    size_is(30, "R6 caller size");
    map(32, 42, 1'b0, "R6 caller base");

    lat_mode = 1;
    for (int i = 9; i >= 0; i--) exp_fill(i, 32 + i);
    op(1'b0, 0, 1'b1, 1'b0);
    chk(exp_q.size() == 0, "R5 fill after flush", exp_q.size(), 0);
    size_is(10, "R6 caller size");
    map(32, 32, 1'b0, "R6 caller base");

    op(1'b0, 0, 1'b1, 1'b0);
    size_is(0, "R6 outermost size");

    // R8 return with nothing saved
    @(negedge clk);
    ret_i = 1'b1;
    @(negedge clk);
    ret_i = 1'b0;
    chk(ready_o == 1'b1, "R8 empty return keeps ready", int'(ready_o), 1);
    size_is(0, "R8 empty return ignored");

    // R8 full depth
    for (int i = 0; i < 4; i++) op(1'b1, 1, 1'b0, 1'b0);
    @(negedge clk);
    call_i = 1'b1; call_size_i = 7'd2;
    @(negedge clk);
    call_i = 1'b0;
    chk(ready_o == 1'b1, "R8 full depth keeps ready", int'(ready_o), 1);
    size_is(1, "R8 full depth ignored");
    map(32, 35, 1'b0, "R8 mapping unchanged");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R4/R5 no pending transfers", exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule